// File: doc/BRIEF.md
# Serial Receiver with Four-Character Holding Buffer and Flow Control

This block turns an asynchronous serial line into bytes. The idle line is high, or mark, and low is space. A character starts with a low start bit. Eight data bits follow, least significant first. Next comes an optional parity bit, then one stop bit. The block times the line from one of two sources. The first is a one-cycle enable pulse at sixteen times the bit rate. The second is an external bit-rate clock, and the line is sampled on its rising edge. Each finished character goes into a four-entry first-in first-out buffer. A parity-error flag and a framing-error flag are stored with the byte. The buffer lets the host read characters late without losing them.

The host sees the oldest entry on the read outputs. A one-cycle read strobe removes that entry. An active-low status output shows either "at least one character waiting" or "buffer full", as the host selects. An active-low request-to-send output can throttle the remote transmitter. When flow control is on, it goes high while all four entries are occupied. It goes low again once a read frees an entry. A character that completes while the buffer is full is dropped, and a sticky overrun flag is raised.

Top module: `uart_rx_fc`

## Requirements
- R1: After reset the following hold: no character is waiting (`rd_valid_o`=0), `ovr_o`=0, `rts_no`=0, and `stat_no`=1.
- R2: In sixteen-times mode a falling line starts a count of `tick16_i` pulses. If the line is still low at the eighth pulse, the start bit is accepted. Each later bit is sampled 16 pulses after the previous sample. The data bits are assembled least significant bit first into `rd_data_o`.
- R3: In sixteen-times mode, a low pulse that ends before the eighth tick is a false start. It produces no character.
- R4: With `mode_1x_i`=1 the line is sampled on each rising edge of `rxclk_i`. The first low sample is the start bit, followed by the data bits, the parity bit if enabled, and the stop bit.
- R5: With `par_en_i`=1 a parity bit follows the data. The count of ones over data and parity must be even when `par_odd_i`=0 and odd when `par_odd_i`=1. A mismatch sets `rd_perr_o` for that entry. With `par_en_i`=0 there is no parity bit and `rd_perr_o` is 0.
- R6: A stop bit sampled low sets `rd_ferr_o` for that entry.
- R7: The buffer holds up to four entries and returns them in arrival order. `rd_i` with `rd_valid_o`=1 removes the oldest entry, and `rd_i` on an empty buffer has no effect.
- R8: A character that completes while four entries are held, with no read in the same cycle, is discarded and sets `ovr_o`. The held entries are unchanged. `ovr_o` stays 1 until `ovr_clr_i` is asserted.
- R9: With `flow_en_i`=1, `rts_no` is 1 exactly while four entries are held. With `flow_en_i`=0, `rts_no` stays 0.
- R10: With `stat_sel_i`=0, `stat_no` is 0 while at least one entry is held. With `stat_sel_i`=1, `stat_no` is 0 only while all four entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data line |
| tick16_i | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxclk_i | input | 1 | External bit-rate clock, sampled on its rising edge |
| mode_1x_i | input | 1 | 1 selects the external bit clock, 0 selects the sixteen-times enable |
| par_en_i | input | 1 | A parity bit follows the data |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| flow_en_i | input | 1 | Automatic request-to-send control enabled |
| stat_sel_i | input | 1 | Status meaning: 0 means ready, 1 means full |
| rd_i | input | 1 | Removes the oldest entry |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_valid_o | output | 1 | At least one entry is held |
| rd_data_o | output | 8 | Data byte of the oldest entry |
| rd_perr_o | output | 1 | Parity error of the oldest entry |
| rd_ferr_o | output | 1 | Framing error of the oldest entry |
| stat_no | output | 1 | Active-low ready or full status |
| rts_no | output | 1 | Active-low request to send |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The overrun case is the hardest to reach. The buffer must already hold four characters, and a fifth must finish with no read in that cycle. The test then has to show that the fifth byte was dropped and the four held bytes are still intact. The stimulus reaches this by sending frames and holding off reads, in directed fills and in random runs where the read count per frame is small. After an overrun, every held entry is drained and compared in order. The directed stimulus also drives a bad stop bit that ends early and a short low glitch on the line. These check that the receiver returns to idle without leaving a phantom character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int unsigned DATA_W = 8;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rxd_i,
  input  logic      tick16_i,
  input  logic      rxclk_i,
  input  logic      mode_1x_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int unsigned BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned OS    = 16;
  localparam int unsigned CW    = $clog2(OS);
  localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  logic [1:0]        rxd_q;
  logic [2:0]        rclk_q;
  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [DATA_W-1:0] shift_q;
  logic              pbit_q;
  logic              push_q;
  rx_entry_t         entry_q;

  logic          rxd_s, rise, strobe, samp;
  logic [CW-1:0] lim;

  // two-flop synchronizers; clock gets a third stage for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_q  <= 2'b11;
      rclk_q <= 3'b000;
    end else begin
      rxd_q  <= {rxd_q[0], rxd_i};
      rclk_q <= {rclk_q[1:0], rxclk_i};
    end
  end

  assign rxd_s  = rxd_q[1];
  assign rise   = rclk_q[1] & ~rclk_q[2];
  assign strobe = mode_1x_i ? rise : tick16_i;
  assign lim    = (state_q == S_START) ? MID : LAST;
  assign samp   = strobe && (mode_1x_i || cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
      push_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (state_q == S_IDLE) begin
        if (strobe && !rxd_s) begin
          cnt_q   <= '0;
          bidx_q  <= '0;
          state_q <= mode_1x_i ? S_DATA : S_START;
        end
      end else begin
        if (strobe) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
        if (samp) begin
          unique case (state_q)
            S_START: state_q <= rxd_s ? S_IDLE : S_DATA;
            S_DATA: begin
              shift_q <= {rxd_s, shift_q[DATA_W-1:1]};
              if (bidx_q == BW'(DATA_W - 1)) state_q <= par_en_i ? S_PAR : S_STOP;
              else bidx_q <= bidx_q + 1'b1;
            end
            S_PAR: begin
              pbit_q  <= rxd_s;
              state_q <= S_STOP;
            end
            S_STOP: begin
              push_q        <= 1'b1;
              entry_q.data  <= shift_q;
              entry_q.ferr  <= ~rxd_s;
              entry_q.perr  <= par_en_i & (^shift_q ^ pbit_q ^ par_odd_i);
              state_q       <= S_IDLE;
            end
            default: state_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign push_o  = push_q;
  assign entry_o = entry_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  rx_entry_t                  entry_i,
  input  logic                       pop_i,
  output rx_entry_t                  head_o,
  output logic                       valid_o,
  output logic                       full_o,
  output logic                       ovr_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (level_q != '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign pop_ok  = pop_i && valid_o;
  // a simultaneous read frees the slot the incoming entry needs
  assign push_ok = push_i && (!full_o || pop_ok);
  assign ovr_o   = push_i && full_o && !pop_ok;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      if (push_ok && !pop_ok)      level_q <= level_q + 1'b1;
      else if (pop_ok && !push_ok) level_q <= level_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign level_o = level_q;
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              rxclk_i,
  input  logic              mode_1x_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              flow_en_i,
  input  logic              stat_sel_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              stat_no,
  output logic              rts_no,
  output logic              ovr_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic          push, fifo_full, ovr_evt, ovr_q;
  rx_entry_t     rx_entry, head;
  logic [LW-1:0] fifo_level;

  uart_rx_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rxd_i     (rxd_i),
    .tick16_i  (tick16_i),
    .rxclk_i   (rxclk_i),
    .mode_1x_i (mode_1x_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .push_o    (push),
    .entry_o   (rx_entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .entry_i (rx_entry),
    .pop_i   (rd_i),
    .head_o  (head),
    .valid_o (rd_valid_o),
    .full_o  (fifo_full),
    .ovr_o   (ovr_evt),
    .level_o (fifo_level)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_evt)   ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign ovr_o     = ovr_q;
  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
  assign rts_no    = flow_en_i & fifo_full;
  assign stat_no   = ~(stat_sel_i ? fifo_full : rd_valid_o);
endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flow_en_i,
  input logic          stat_sel_i,
  input logic          ovr_clr_i,
  input logic          rts_no,
  input logic          stat_no,
  input logic          ovr_o,
  input logic          rd_valid_o,
  input logic [LW-1:0] fifo_level
);
  a_r9_rts_tracks_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && stat_sel_i) |-> (rts_no == !stat_no));

  a_r10_ready_tracks_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_sel_i) |-> (stat_no == (fifo_level == '0)));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_level) <= int'(DEPTH));

  a_r7_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fifo_level) - int'($past(fifo_level)) <= 1) &&
    (int'($past(fifo_level)) - int'(fifo_level) <= 1));

  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  a_r8_ovr_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> (int'($past(fifo_level)) == int'(DEPTH)));

  a_r7_valid_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (fifo_level != '0));
endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flow_en_i  (flow_en_i),
  .stat_sel_i (stat_sel_i),
  .ovr_clr_i  (ovr_clr_i),
  .rts_no     (rts_no),
  .stat_no    (stat_no),
  .ovr_o      (ovr_o),
  .rd_valid_o (rd_valid_o),
  .fifo_level (fifo_level)
);

// File: tb/uart_rx_fc_test.sv
module uart_rx_fc_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPER       = 4;           // clocks per tick16
  localparam int BITC       = 16 * TPER;   // clocks per bit in 16X mode
  localparam int DEPTH      = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, tick16 = 1'b0, rxclk = 1'b0, mode_1x = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, flow_en = 1'b1, stat_sel = 1'b0;
  logic rd = 1'b0, ovr_clr = 1'b0;
  logic rd_valid, rd_perr, rd_ferr, stat_n, rts_n, ovr;
  logic [7:0] rd_data;

  int errors = 0, checks = 0, tcnt = 0;
  logic exp_ovr = 1'b0;
  logic [9:0] model [$];   // {perr, ferr, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TPER - 1);
  end

  uart_rx_fc #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick16), .rxclk_i(rxclk),
    .mode_1x_i(mode_1x), .par_en_i(par_en), .par_odd_i(par_odd), .flow_en_i(flow_en),
    .stat_sel_i(stat_sel), .rd_i(rd), .ovr_clr_i(ovr_clr), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .stat_no(stat_n),
    .rts_no(rts_n), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_stat(input int n);
    return stat_sel ? !(n == DEPTH) : !(n > 0);
  endfunction

  task automatic check_status(input string req);
    int n = model.size();
    chk(rd_valid == (n > 0), req, "rd_valid", rd_valid, n > 0);
    chk(rts_n == (flow_en && n == DEPTH), "R9", "rts_no", rts_n, flow_en && n == DEPTH);
    chk(stat_n == exp_stat(n), "R10", "stat_no", stat_n, exp_stat(n));
    chk(ovr == exp_ovr, "R8", "ovr", ovr, exp_ovr);
  endtask

  task automatic emit(input logic b, input int len);
    if (mode_1x) begin
      rxd = b; rxclk = 1'b0;
      repeat (4) @(negedge clk);
      rxclk = 1'b1;
      repeat (4) @(negedge clk);
      rxclk = 1'b0;
    end else begin
      rxd = b;
      repeat (len) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit flip, input bit bad_stop);
    logic p;
    p = ^d ^ par_odd ^ flip;
    emit(1'b0, BITC);
    for (int i = 0; i < 8; i++) emit(d[i], BITC);
    if (par_en) emit(p, BITC);
    emit(!bad_stop, bad_stop ? 40 : BITC);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    if (model.size() < DEPTH) model.push_back({par_en & flip, bad_stop, d});
    else exp_ovr = 1'b1;
  endtask

  task automatic do_read(input string req);
    if (model.size() == 0) return;
    chk(rd_data == model[0][7:0], req, "data", rd_data, model[0][7:0]);
    chk(rd_perr == model[0][9], "R5", "perr", rd_perr, model[0][9]);
    chk(rd_ferr == model[0][8], "R6", "ferr", rd_ferr, model[0][8]);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    void'(model.pop_front());
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) do_read(req);
    check_status(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2681));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_status("R1");

    // R2 16X basic
    send(8'hA5, 0, 0); check_status("R2"); drain("R2");
    send(8'h01, 0, 0); drain("R2");
    // R4 external 1X clock
    mode_1x = 1'b1;
    send(8'h3C, 0, 0); check_status("R4"); drain("R4");
    send(8'h80, 0, 0); drain("R4");
    mode_1x = 1'b0;
    // R5 parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 0, 0); send(8'h07, 1, 0);
    par_odd = 1'b1; send(8'hF0, 0, 0); send(8'hF0, 1, 0);
    drain("R5");
    par_en = 1'b0;
    // R6 framing error
    send(8'h55, 0, 1); check_status("R6"); drain("R6");
    mode_1x = 1'b1; send(8'hAA, 0, 1); drain("R6"); mode_1x = 1'b0;
    // R3 short glitch
    rxd = 1'b0; repeat (4 * TPER) @(negedge clk);
    rxd = 1'b1; repeat (4 * BITC) @(negedge clk);
    check_status("R3");
    // R7 R8 R9 R10 fill, overrun, flow control
    stat_sel = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), 0, 0);
    check_status("R9");
    send(8'hEE, 0, 0); check_status("R8");
    flow_en = 1'b0; @(negedge clk); check_status("R9"); flow_en = 1'b1;
    do_read("R7"); check_status("R9");
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk); // not sticky-cleared by reads
    void'(model.pop_front());
    check_status("R8");
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; exp_ovr = 1'b0; @(negedge clk);
    check_status("R8");
    drain("R7");
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    check_status("R7");
    stat_sel = 1'b0;

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [31:0] r = $urandom;
      mode_1x  = r[0];
      par_en   = r[1];
      par_odd  = r[2];
      stat_sel = r[3];
      flow_en  = r[4] | r[5];
      send(r[15:8], r[18:16] == 0, r[21:19] == 0);
      check_status("R2");
      for (int k = 0; k < int'(r[23:22]) && k < 2; k++) do_read("R7");
      if (r[26:24] == 0 && exp_ovr) begin
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; exp_ovr = 1'b0; @(negedge clk);
        check_status("R8");
      end
    end
    drain("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule